// File: doc/BRIEF.md
# AHB-Lite to APB Bridge with Posted Writes

This block sits between an AHB-Lite slave port and an APB master port that runs on the same clock. Each single AHB-Lite transfer becomes one APB access: one setup cycle followed by access cycles that last until the selected peripheral raises PREADY. The address is decoded into a one-hot select over 32 peripheral slots. Most slots cover 4 KB, but a few are wider, and the map has gaps. An address that hits no slot receives an AHB error response and never reaches the APB side.

A run-time mode input chooses how writes complete. In the default non-posted mode, the AHB data phase of a write stretches until the APB access ends, so a slow peripheral stalls the AHB master. In posted mode, the bridge finishes the AHB write as soon as it holds the address and the data, then completes the APB write on its own. Any transfer that arrives meanwhile waits until that write is done, so ordering is kept. Reads always wait for the peripheral. An APB error on a posted write cannot be returned on the bus any more, so it sets a sticky flag instead.

Top module: `apb_post_bridge`

## Requirements
- R1: After reset, hreadyout is 1, hresp is 0, psel is all zero, penable is 0 and post_err is 0.
- R2: Bit n of psel selects slot n. Slots 0–7 are the 4 KB windows from 0x20000000. Slot 8 covers 0x20008000–0x20009FFF. Slot 9 covers 0x20080000–0x200FFFFF. Slots 10–23 are the 4 KB windows from 0x20100000. Slot 24 covers 0x20110000–0x20111FFF and slot 25 covers 0x20112000–0x20113FFF. Slots 26–28 are the 4 KB windows from 0x20120000, and slots 29–31 are the 4 KB windows from 0x20124000. At most one psel bit is high at any time.
- R3: Each APB access has exactly one cycle with psel set and penable low, then cycles with penable high until pready. paddr, pwrite, pwdata and psel do not change while penable is high. The written data equals the hwdata of the AHB data phase.
- R4: In non-posted mode, a write's data phase lasts 2+W cycles when the peripheral holds pready low for W access cycles, with hresp 0.
- R5: Reads are never posted. A read's data phase lasts 2+W cycles in either mode, and hrdata equals prdata in the completing cycle.
- R6: In posted mode, a write to a mapped slot completes on the AHB side in its first data-phase cycle, and the APB write follows with the captured address and data.
- R7: A transfer accepted while a posted write is still on APB stalls with hreadyout low until that write ends. It then runs its own APB access, and the APB side sees the posted write first.
- R8: An unmapped address gets a two-cycle error: hresp is 1 in both cycles, hreadyout is 0 in the first and 1 in the second. No psel bit is raised.
- R9: pslverr at the end of a non-posted access gives the same two-cycle error response as R8.
- R10: pslverr at the end of a posted write sets post_err, which stays high until reset. The AHB write itself ends with hresp 0.
- R11: The mode input is taken when a transfer starts. Changing it while a transfer is in flight does not change how that transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the AHB and APB sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| posted_en | input | 1 | 1 selects posted writes, 0 selects non-posted writes |
| hsel | input | 1 | AHB slave select |
| haddr | input | 32 | AHB address |
| htrans | input | 2 | AHB transfer type; NONSEQ and SEQ both start a transfer |
| hwrite | input | 1 | AHB write when 1 |
| hwdata | input | 32 | AHB write data, valid during the data phase |
| hready_in | input | 1 | AHB bus ready; a transfer is accepted only when it is 1 |
| hreadyout | output | 1 | Bridge ready; 0 extends the current data phase |
| hresp | output | 1 | 1 signals an error response |
| hrdata | output | 32 | AHB read data |
| paddr | output | 32 | APB address |
| psel | output | 32 | One-hot APB slot select |
| penable | output | 1 | APB access phase |
| pwrite | output | 1 | APB write when 1 |
| pwdata | output | 32 | APB write data |
| prdata | input | 32 | APB read data |
| pready | input | 1 | APB peripheral ready |
| pslverr | input | 1 | APB peripheral error |
| post_err | output | 1 | Sticky flag for an APB error on a posted write |

## Verification
A wrong slot index or a corrupt held address shows at psel in the same cycle the setup phase starts. The bench compares psel against its own address map on every clock, so such a fault is caught at once. A lost pending transfer or a wrong mode flag does not show as a bad value. It shows as a data phase that is too short or too long, so the bench counts the exact data-phase length of every transfer. Mis-captured write data appears in the peripheral's log within one access, and a missed posted error leaves post_err low when it is next read.

// File: rtl/apb_bridge_pkg.sv
package apb_bridge_pkg;

    localparam int BR_AW = 32;
    localparam int BR_DW = 32;
    localparam int BR_NS = 32;
    localparam int BR_SW = $clog2(BR_NS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_ERR1,
        ST_ERR2
    } br_state_e;

    typedef struct packed {
        br_state_e          state;
        logic [BR_AW-1:0]   addr;
        logic               write;
        logic [BR_SW-1:0]   slot;
        logic               posted;
        logic [BR_DW-1:0]   wdata;
        logic               pend;
        logic [BR_AW-1:0]   pend_addr;
        logic               pend_write;
        logic               post_err;
    } br_regs_t;

endpackage

// File: rtl/slot_map_decode.sv
module slot_map_decode #(
    parameter int AW = 32,
    parameter int SW = 5
) (
    input  logic [AW-1:12] page,
    output logic           hit,
    output logic [SW-1:0]  idx
);
    localparam int HW = AW - 16;
    localparam logic [HW-1:0] LOW_BANK  = HW'(16'h2000);
    localparam logic [HW-1:0] HIGH_BANK = HW'(16'h2010);
    localparam logic [HW-1:0] MAC_BANK  = HW'(16'h2011);
    localparam logic [HW-1:0] IO_BANK   = HW'(16'h2012);
    localparam logic [AW-20:0] WIDE_WIN = (AW-19)'(13'h0401);

    logic [3:0] pg;
    assign pg = page[15:12];

    always_comb begin
        hit = 1'b0;
        idx = '0;
        if (page[AW-1:16] == LOW_BANK) begin
            if (pg <= 4'd7) begin
                hit = 1'b1;
                idx = SW'(pg);
            end else if (pg[3:1] == 3'b100) begin
                hit = 1'b1;
                idx = SW'(8);
            end
        end else if (page[AW-1:19] == WIDE_WIN) begin
            hit = 1'b1;
            idx = SW'(9);
        end else if (page[AW-1:16] == HIGH_BANK) begin
            if (pg <= 4'd13) begin
                hit = 1'b1;
                idx = SW'(10) + SW'(pg);
            end
        end else if (page[AW-1:16] == MAC_BANK) begin
            if (pg[3:2] == 2'b00) begin
                hit = 1'b1;
                idx = SW'(24) + SW'(pg[1]);
            end
        end else if (page[AW-1:16] == IO_BANK) begin
            if (pg <= 4'd2) begin
                hit = 1'b1;
                idx = SW'(26) + SW'(pg);
            end else if (pg >= 4'd4 && pg <= 4'd6) begin
                hit = 1'b1;
                idx = SW'(29) + SW'(pg - 4'd4);
            end
        end
    end
endmodule

// File: rtl/slot_onehot.sv
module slot_onehot #(
    parameter int NS = 32,
    parameter int SW = 5
) (
    input  logic          en,
    input  logic [SW-1:0] idx,
    output logic [NS-1:0] sel
);
    for (genvar i = 0; i < NS; i++) begin : g_sel
        assign sel[i] = en && (idx == SW'(i));
    end
endmodule

// File: rtl/apb_post_bridge.sv
module apb_post_bridge
    import apb_bridge_pkg::*;
#(
    parameter int AW = BR_AW,
    parameter int DW = BR_DW,
    parameter int NS = BR_NS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          posted_en,
    input  logic          hsel,
    input  logic [AW-1:0] haddr,
    input  logic [1:0]    htrans,
    input  logic          hwrite,
    input  logic [DW-1:0] hwdata,
    input  logic          hready_in,
    output logic          hreadyout,
    output logic          hresp,
    output logic [DW-1:0] hrdata,
    output logic [AW-1:0] paddr,
    output logic [NS-1:0] psel,
    output logic          penable,
    output logic          pwrite,
    output logic [DW-1:0] pwdata,
    input  logic [DW-1:0] prdata,
    input  logic          pready,
    input  logic          pslverr,
    output logic          post_err
);
    localparam int SW = $clog2(NS);

    br_regs_t st_q, st_d;

    logic          req;
    logic          from_pend;
    logic [AW-1:0] src_addr;
    logic          src_write;
    logic          src_hit;
    logic [SW-1:0] src_idx;
    logic          apb_busy;

    assign req       = hsel && (htrans == 2'b10 || htrans == 2'b11) && hready_in;
    assign from_pend = (st_q.state == ST_ACCESS) && st_q.pend;
    assign src_addr  = from_pend ? st_q.pend_addr  : haddr;
    assign src_write = from_pend ? st_q.pend_write : hwrite;

    slot_map_decode #(.AW(AW), .SW(SW)) u_decode (
        .page (src_addr[AW-1:12]),
        .hit  (src_hit),
        .idx  (src_idx)
    );

    assign apb_busy = (st_q.state == ST_SETUP) || (st_q.state == ST_ACCESS);

    slot_onehot #(.NS(NS), .SW(SW)) u_onehot (
        .en  (apb_busy),
        .idx (st_q.slot),
        .sel (psel)
    );

    function automatic br_regs_t launch(input br_regs_t cur, input logic [AW-1:0] a,
                                        input logic w, input logic hit,
                                        input logic [SW-1:0] idx, input logic pmode);
        br_regs_t r;
        r        = cur;
        r.addr   = a;
        r.write  = w;
        r.slot   = idx;
        r.posted = w && pmode;
        r.state  = hit ? ST_SETUP : ST_ERR1;
        return r;
    endfunction

    always_comb begin
        st_d      = st_q;
        hreadyout = 1'b1;
        hresp     = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (req) st_d = launch(st_q, src_addr, src_write, src_hit, src_idx, posted_en);
            end
            ST_SETUP: begin
                hreadyout  = st_q.posted;
                st_d.wdata = hwdata;
                st_d.state = ST_ACCESS;
                if (st_q.posted && req) begin
                    st_d.pend       = 1'b1;
                    st_d.pend_addr  = haddr;
                    st_d.pend_write = hwrite;
                end
            end
            ST_ACCESS: begin
                hreadyout = 1'b0;
                if (pready) begin
                    if (st_q.posted) begin
                        if (pslverr) st_d.post_err = 1'b1;
                        if (st_q.pend) begin
                            st_d      = launch(st_d, src_addr, src_write, src_hit, src_idx, posted_en);
                            st_d.pend = 1'b0;
                        end else begin
                            st_d.state = ST_IDLE;
                        end
                    end else if (pslverr) begin
                        hresp      = 1'b1;
                        st_d.state = ST_ERR2;
                    end else begin
                        hreadyout  = 1'b1;
                        st_d.state = ST_IDLE;
                        if (req) st_d = launch(st_q, src_addr, src_write, src_hit, src_idx, posted_en);
                    end
                end
            end
            ST_ERR1: begin
                hreadyout  = 1'b0;
                hresp      = 1'b1;
                st_d.state = ST_ERR2;
            end
            ST_ERR2: begin
                hresp      = 1'b1;
                st_d.state = ST_IDLE;
                if (req) st_d = launch(st_q, src_addr, src_write, src_hit, src_idx, posted_en);
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign paddr    = st_q.addr;
    assign pwrite   = st_q.write;
    assign penable  = (st_q.state == ST_ACCESS);
    assign pwdata   = (st_q.state == ST_SETUP) ? hwdata : st_q.wdata;
    assign hrdata   = prdata;
    assign post_err = st_q.post_err;

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(psel));

    // R3
    setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(penable) |-> $past(psel != '0 && !penable));

    // R3
    access_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> ($stable(paddr) && $stable(pwrite) && $stable(pwdata) && $stable(psel)));

    // R8
    err_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hreadyout) |=> (hresp && hreadyout));

    // R8
    unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_ERR1) |-> (psel == '0));

    // R10
    post_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_err |=> post_err);

    // R7
    pend_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> (penable && st_q.posted));
endmodule

// File: tb/apb_post_bridge_bench.sv
module apb_post_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        posted_en = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [31:0] hwdata = '0;
    logic        hreadyout, hresp;
    logic [31:0] hrdata, paddr, pwdata;
    logic [31:0] psel;
    logic        penable, pwrite, post_err;
    logic [31:0] prdata = '0;
    logic        pready = 1'b0;
    logic        pslverr = 1'b0;

    int total = 0;
    int bad = 0;
    int wait_n = 0;
    bit err_en = 1'b0;
    int cnt = 0;
    logic [64:0] plog[$];

    always #2.5 clk = ~clk;

    apb_post_bridge u_apb_post_bridge (
        .clk(clk), .rst_n(rst_n), .posted_en(posted_en),
        .hsel(hsel), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
        .hwdata(hwdata), .hready_in(hreadyout), .hreadyout(hreadyout),
        .hresp(hresp), .hrdata(hrdata), .paddr(paddr), .psel(psel),
        .penable(penable), .pwrite(pwrite), .pwdata(pwdata),
        .prdata(prdata), .pready(pready), .pslverr(pslverr), .post_err(post_err)
    );

    function automatic int ref_slot(input logic [31:0] a);
        longint u = a;
        if (u >= 64'h20000000 && u <= 64'h20007FFF) return int'((u - 64'h20000000) >> 12);
        if (u >= 64'h20008000 && u <= 64'h20009FFF) return 8;
        if (u >= 64'h20080000 && u <= 64'h200FFFFF) return 9;
        if (u >= 64'h20100000 && u <= 64'h2010DFFF) return 10 + int'((u - 64'h20100000) >> 12);
        if (u >= 64'h20110000 && u <= 64'h20111FFF) return 24;
        if (u >= 64'h20112000 && u <= 64'h20113FFF) return 25;
        if (u >= 64'h20120000 && u <= 64'h20122FFF) return 26 + int'((u - 64'h20120000) >> 12);
        if (u >= 64'h20124000 && u <= 64'h20126FFF) return 29 + int'((u - 64'h20124000) >> 12);
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // peripheral model
    always @(negedge clk) begin
        if (psel != '0 && penable) begin
            if (cnt == wait_n) begin
                pready  = 1'b1;
                pslverr = err_en;
                prdata  = paddr ^ 32'h5A5A0F0F;
                plog.push_back({pwrite, paddr, pwdata});
            end else begin
                pready  = 1'b0;
                pslverr = 1'b0;
                cnt++;
            end
        end else begin
            pready  = 1'b0;
            pslverr = 1'b0;
            cnt     = 0;
        end
    end

    // per-clock decode comparison (R2) and phase sanity (R3)
    always @(negedge clk) begin
        #1;
        if (rst_n && psel != '0) begin
            int s;
            s = ref_slot(paddr);
            chk(s >= 0 && psel == (32'd1 << s), "R2 psel vs address map", psel,
                (s >= 0) ? (64'd1 << s) : 0);
        end
        if (rst_n && penable && psel == '0) chk(1'b0, "R3 penable without psel", 0, 1);
    end

    int  r_cyc;
    bit  r_err;
    bit  r_apb;
    logic [31:0] r_rd;

    task automatic xfer(input logic [31:0] a, input bit w, input logic [31:0] d);
        hsel = 1'b1; htrans = 2'b10; haddr = a; hwrite = w;
        while (!hreadyout) begin @(negedge clk); #1; end
        @(negedge clk); #1;
        hsel = 1'b0; htrans = 2'b00; hwdata = d;
        r_cyc = 0; r_err = 1'b0; r_apb = 1'b0;
        forever begin
            r_cyc++;
            if (hresp) r_err = 1'b1;
            if (psel != '0) r_apb = 1'b1;
            if (hreadyout) begin r_rd = hrdata; break; end
            @(negedge clk); #1;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    bit done = 1'b0;
    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [64:0] e;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(hreadyout == 1'b1, "R1 hreadyout", hreadyout, 1);
        chk(hresp == 1'b0, "R1 hresp", hresp, 0);
        chk(psel == '0 && !penable, "R1 apb idle", psel, 0);
        chk(post_err == 1'b0, "R1 post_err", post_err, 0);
        rst_n = 1'b1;
        idle(2);

        // R4 non-posted write, no wait
        plog.delete(); wait_n = 0;
        xfer(32'h20003010, 1'b1, 32'hCAFE0001);
        chk(r_cyc == 2 && !r_err, "R4 write W=0 cycles", r_cyc, 2);
        idle(1);
        e = {1'b1, 32'h20003010, 32'hCAFE0001};
        chk(plog.size() == 1 && plog[0] == e, "R3 write data on APB", plog.size() ? plog[0] : 0, e);

        // R4 non-posted write to the wide slot 9, two waits
        plog.delete(); wait_n = 2;
        xfer(32'h200ABCD0, 1'b1, 32'h12345678);
        chk(r_cyc == 4 && !r_err, "R4 write W=2 cycles", r_cyc, 4);

        // R5 read slot 8 upper half, one wait
        wait_n = 1;
        xfer(32'h20009004, 1'b0, 32'h0);
        chk(r_cyc == 3 && !r_err, "R5 read W=1 cycles", r_cyc, 3);
        chk(r_rd == (32'h20009004 ^ 32'h5A5A0F0F), "R5 read data", r_rd, 32'h20009004 ^ 32'h5A5A0F0F);

        // R5 read slot 25
        wait_n = 0;
        xfer(32'h20113010, 1'b0, 32'h0);
        chk(r_cyc == 2 && r_rd == (32'h20113010 ^ 32'h5A5A0F0F), "R5 read slot 25", r_rd,
            32'h20113010 ^ 32'h5A5A0F0F);

        // R8 unmapped addresses
        xfer(32'h2000A000, 1'b1, 32'h1);
        chk(r_cyc == 2 && r_err && !r_apb, "R8 unmapped after slot 8", r_cyc, 2);
        xfer(32'h20123000, 1'b0, 32'h0);
        chk(r_cyc == 2 && r_err && !r_apb, "R8 unmapped gap 28/29", r_cyc, 2);

        // R9 peripheral error, non-posted
        err_en = 1'b1;
        xfer(32'h20126000, 1'b1, 32'h55);
        chk(r_cyc == 3 && r_err, "R9 pslverr error response", r_cyc, 3);
        err_en = 1'b0;
        chk(post_err == 1'b0, "R10 no flag on non-posted error", post_err, 0);

        // R6 posted write, then R7 read held behind it
        posted_en = 1'b1; wait_n = 3; plog.delete();
        xfer(32'h20110008, 1'b1, 32'hBEEF0024);
        chk(r_cyc == 1 && !r_err, "R6 posted write completes at once", r_cyc, 1);
        xfer(32'h20102000, 1'b0, 32'h0);
        chk(r_cyc == 9, "R7 read stalled behind posted write", r_cyc, 9);
        chk(r_rd == (32'h20102000 ^ 32'h5A5A0F0F), "R7 held read data", r_rd, 32'h20102000 ^ 32'h5A5A0F0F);
        e = {1'b1, 32'h20110008, 32'hBEEF0024};
        chk(plog.size() == 2 && plog[0] == e, "R7 posted write first on APB", plog.size() ? plog[0] : 0, e);
        chk(plog.size() == 2 && plog[1][64] == 1'b0, "R7 read second on APB", plog.size(), 2);

        // R5 read stays non-posted in posted mode
        wait_n = 0;
        xfer(32'h20000004, 1'b0, 32'h0);
        chk(r_cyc == 2, "R5 read not posted", r_cyc, 2);

        // R8 unmapped in posted mode
        xfer(32'h20200000, 1'b1, 32'h9);
        chk(r_cyc == 2 && r_err && !r_apb, "R8 unmapped posted write", r_cyc, 2);

        // R10 error on a posted write
        err_en = 1'b1;
        xfer(32'h2010D000, 1'b1, 32'h77);
        chk(r_cyc == 1 && !r_err, "R10 posted write OKAY on AHB", r_err, 0);
        idle(3);
        err_en = 1'b0;
        chk(post_err == 1'b1, "R10 post_err set", post_err, 1);
        xfer(32'h20001000, 1'b0, 32'h0);
        idle(2);
        chk(post_err == 1'b1, "R10 post_err sticky", post_err, 1);

        // R11 mode change during a non-posted write
        posted_en = 1'b0; wait_n = 4;
        fork
            xfer(32'h20007008, 1'b1, 32'hA0A0A0A0);
            begin repeat (2) @(negedge clk); posted_en = 1'b1; end
        join
        chk(r_cyc == 6 && !r_err, "R11 in-flight write stays non-posted", r_cyc, 6);
        xfer(32'h20121000, 1'b1, 32'h3);
        chk(r_cyc == 1, "R11 next write uses new mode", r_cyc, 1);
        posted_en = 1'b0;
        idle(8);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule